// File: doc/BRIEF.md
# Single-Cycle 64-bit Integer Core (Eight-Instruction Subset)

This block is a small 64-bit processor core that finishes one instruction on every rising clock edge. It executes doubleword load and store, register-register add, subtract, AND and OR, add-immediate, and branch-if-equal. Inside it are:
- a program counter;
- a 32-entry register file of 64-bit registers, with two read ports and one write port;
- an immediate builder;
- an ALU that also gives a zero indication;
- a combinational control decoder;
- the logic that selects the next PC.

Instruction storage and data storage are plain internal arrays. A preload port fills them, normally while the core is held in reset. The architectural effect of each instruction is visible on three observation buses: the register write-back bus, the store bus and the PC output. These buses are combinational views of the instruction currently being executed.

Reset is asynchronous and active low. Its release passes through a two-stage synchronizer. Only after that does the core start committing state.

Top module: `sc64_core`

## Requirements
- R1: While rst_n is low, pc_o is 0 and wb_we_o and st_we_o are 0, and asserting rst_n forces pc_o to 0 without waiting for a clock. After release the PC stays 0 through the first two rising edges. The instruction at address 0 commits on the third rising edge, after which pc_o is 4.
- R2: Opcode 0110011 is a register-register operation on rs1 (bits 19:15) and rs2 (bits 24:20), written to rd (bits 11:7). funct3 000 with funct7 0000000 adds, and funct3 000 with funct7 0100000 subtracts rs1 minus rs2. funct3 111 with funct7 0000000 is bitwise AND, and funct3 110 with funct7 0000000 is bitwise OR.
- R3: Opcode 0010011 with funct3 000 writes rs1 plus the sign-extended 12-bit immediate taken from bits 31:20 into rd.
- R4: Opcode 0000011 with funct3 011 loads a doubleword. It writes into rd the data-memory word indexed by bits above bit 2 of rs1 plus the sign-extended bits 31:20.
- R5: Opcode 0100011 with funct3 011 stores rs2 at the address rs1 plus the sign-extended immediate {bits 31:25, bits 11:7}. During that cycle it raises st_we_o with that address and data. It writes no register, and a later load from the same address returns the stored value.
- R6: Opcode 1100011 with funct3 000 compares rs1 and rs2. When they are equal, the next PC is the current PC plus twice the sign-extended 12-bit field {bit 31, bit 7, bits 30:25, bits 11:8}, so a field of -16 moves the PC by -32. The branch writes neither registers nor memory.
- R7: Every instruction other than a taken branch advances the PC by 4, and that includes a branch whose operands differ.
- R8: Register 0 always reads as zero. A write aimed at it is dropped and is not reported on wb_we_o.
- R9: An opcode or funct combination not listed above executes as a no-op: no register write, no store, and the PC advances by 4.
- R10: The PC, the register file and the data memory change only on a rising clock edge, and one instruction completes per cycle. A value written by one instruction is therefore visible to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized internally |
| prog_we | input | 1 | Preload write strobe |
| prog_dmem | input | 1 | Preload target: 0 instruction array, 1 data array |
| prog_addr | input | PROG_AW | Preload word index |
| prog_data | input | 64 | Preload data (instruction array uses bits 31:0) |
| pc_o | output | 64 | Address of the instruction being executed |
| wb_we_o | output | 1 | A register write commits at the next edge |
| wb_rd_o | output | 5 | Destination register of that write |
| wb_data_o | output | 64 | Value being written |
| st_we_o | output | 1 | A store commits at the next edge |
| st_addr_o | output | 64 | Byte address of the store |
| st_data_o | output | 64 | Doubleword being stored |

## Verification
The hardest state to reach from the ports is a branch that goes backwards over code that has already run. The PC must wrap to an earlier address while the register file still holds values from the first pass. The program reaches it with a taken branch of field -16 at address 64, which lands on a store that already ran at address 32, so the replayed store must show the same address and data. The sequence before that stores and then reloads through memory, attempts a write to register 0, and executes an unknown opcode after a forward branch has jumped over a word that must never run. A reset asserted in the middle of the run then checks the asynchronous clear of the PC and the exact cycle in which the first instruction commits again.

// File: rtl/sc64_pkg.sv
package sc64_pkg;
  localparam int XLEN = 64;
  localparam int ILEN = 32;

  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_BR    = 7'b1100011;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_I = 2'd0,
    IMM_S = 2'd1,
    IMM_B = 2'd2
  } imm_sel_e;

  typedef struct packed {
    logic     legal;
    logic     reg_write;
    logic     alu_src;
    logic     mem_read;
    logic     mem_write;
    logic     mem_to_reg;
    logic     branch;
    alu_op_e  alu_op;
    imm_sel_e imm_sel;
  } ctrl_t;
endpackage

// File: rtl/sc64_decode.sv
module sc64_decode
  import sc64_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{legal: 1'b0, reg_write: 1'b0, alu_src: 1'b0, mem_read: 1'b0,
             mem_write: 1'b0, mem_to_reg: 1'b0, branch: 1'b0,
             alu_op: ALU_ADD, imm_sel: IMM_I};
    unique case (opcode)
      OPC_LOAD: if (funct3 == 3'b011) begin
        ctrl.legal      = 1'b1;
        ctrl.reg_write  = 1'b1;
        ctrl.alu_src    = 1'b1;
        ctrl.mem_read   = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OPC_STORE: if (funct3 == 3'b011) begin
        ctrl.legal     = 1'b1;
        ctrl.alu_src   = 1'b1;
        ctrl.mem_write = 1'b1;
        ctrl.imm_sel   = IMM_S;
      end
      OPC_IMM: if (funct3 == 3'b000) begin
        ctrl.legal     = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.alu_src   = 1'b1;
      end
      OPC_BR: if (funct3 == 3'b000) begin
        ctrl.legal   = 1'b1;
        ctrl.branch  = 1'b1;
        ctrl.alu_op  = ALU_SUB;
        ctrl.imm_sel = IMM_B;
      end
      OPC_REG: begin
        unique case ({funct7, funct3})
          {7'b0000000, 3'b000}: begin ctrl.legal = 1'b1; ctrl.alu_op = ALU_ADD; end
          {7'b0100000, 3'b000}: begin ctrl.legal = 1'b1; ctrl.alu_op = ALU_SUB; end
          {7'b0000000, 3'b111}: begin ctrl.legal = 1'b1; ctrl.alu_op = ALU_AND; end
          {7'b0000000, 3'b110}: begin ctrl.legal = 1'b1; ctrl.alu_op = ALU_OR;  end
          default: ctrl.legal = 1'b0;
        endcase
        ctrl.reg_write = ctrl.legal;
      end
      default: ctrl.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/sc64_immgen.sv
module sc64_immgen
  import sc64_pkg::*;
#(
  parameter int W = XLEN,
  parameter int FW = 12
) (
  input  logic [ILEN-1:0] instr,
  input  imm_sel_e        sel,
  output logic [W-1:0]    imm
);
  logic [FW-1:0] field;

  always_comb begin
    unique case (sel)
      IMM_S:   field = {instr[31:25], instr[11:7]};
      IMM_B:   field = {instr[31], instr[7], instr[30:25], instr[11:8]};
      default: field = instr[31:20];
    endcase
    imm = {{(W-FW){field[FW-1]}}, field};
  end
endmodule

// File: rtl/sc64_alu.sv
module sc64_alu
  import sc64_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
    zero = (y == '0);
  end
endmodule

// File: rtl/sc64_regfile.sv
module sc64_regfile #(
  parameter int NREG = 32,
  parameter int W = 64,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] regs_q [NREG];
  logic         wr_en;

  assign wr_en = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (wr_en) regs_q[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
endmodule

// File: rtl/sc64_core.sv
module sc64_core
  import sc64_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64,
  parameter int NREG = 32,
  localparam int IA = $clog2(IMEM_DEPTH),
  localparam int DA = $clog2(DMEM_DEPTH),
  localparam int RA = $clog2(NREG),
  localparam int PROG_AW = (IA > DA) ? IA : DA
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_we,
  input  logic               prog_dmem,
  input  logic [PROG_AW-1:0] prog_addr,
  input  logic [XLEN-1:0]    prog_data,
  output logic [XLEN-1:0]    pc_o,
  output logic               wb_we_o,
  output logic [RA-1:0]      wb_rd_o,
  output logic [XLEN-1:0]    wb_data_o,
  output logic               st_we_o,
  output logic [XLEN-1:0]    st_addr_o,
  output logic [XLEN-1:0]    st_data_o
);
  // reset release synchronizer
  logic [1:0] sync_q;
  logic       run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign run = sync_q[1];

  // storage arrays
  logic [ILEN-1:0] imem_q [IMEM_DEPTH];
  logic [XLEN-1:0] dmem_q [DMEM_DEPTH];

  // program counter
  logic [XLEN-1:0] pc_q, pc_d;
  logic            pc_en;

  // datapath
  logic [ILEN-1:0] instr;
  ctrl_t           ctrl;
  logic [XLEN-1:0] imm, rs1_d, rs2_d, alu_b, alu_y, ld_data, wb_data;
  logic            alu_zero, take;
  logic [RA-1:0]   rd, rs1, rs2;
  logic [DA-1:0]   d_idx;
  logic            reg_we, mem_we;

  assign instr = imem_q[pc_q[IA+1:2]];
  assign rd    = instr[11:7];
  assign rs1   = instr[19:15];
  assign rs2   = instr[24:20];

  sc64_decode u_dec (
    .opcode (instr[6:0]),
    .funct3 (instr[14:12]),
    .funct7 (instr[31:25]),
    .ctrl   (ctrl)
  );

  sc64_immgen #(.W(XLEN)) u_imm (
    .instr (instr),
    .sel   (ctrl.imm_sel),
    .imm   (imm)
  );

  sc64_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk (clk),
    .we  (reg_we),
    .wa  (rd),
    .wd  (wb_data),
    .ra1 (rs1),
    .rd1 (rs1_d),
    .ra2 (rs2),
    .rd2 (rs2_d)
  );

  assign alu_b = ctrl.alu_src ? imm : rs2_d;

  sc64_alu #(.W(XLEN)) u_alu (
    .a    (rs1_d),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign d_idx   = alu_y[DA+2:3];
  assign ld_data = dmem_q[d_idx];
  assign wb_data = ctrl.mem_to_reg ? ld_data : alu_y;
  assign reg_we  = run && ctrl.reg_write;
  assign mem_we  = run && ctrl.mem_write;
  assign take    = ctrl.branch && alu_zero;

  // next PC selection
  always_comb begin
    pc_en = run;
    if (take) pc_d = pc_q + (imm << 1);
    else      pc_d = pc_q + XLEN'(4);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  // storage writes
  always_ff @(posedge clk) begin
    if (prog_we && !prog_dmem) imem_q[prog_addr[IA-1:0]] <= prog_data[ILEN-1:0];
  end

  always_ff @(posedge clk) begin
    if (prog_we && prog_dmem) dmem_q[prog_addr[DA-1:0]] <= prog_data;
    else if (mem_we)          dmem_q[d_idx] <= rs2_d;
  end

  // observation buses
  assign pc_o      = pc_q;
  assign wb_we_o   = reg_we && (rd != '0);
  assign wb_rd_o   = rd;
  assign wb_data_o = wb_data;
  assign st_we_o   = mem_we;
  assign st_addr_o = alu_y;
  assign st_data_o = rs2_d;

  logic unused_bits;
  assign unused_bits = ^{pc_q[1:0], pc_q[XLEN-1:IA+2], alu_y[2:0], alu_y[XLEN-1:DA+3],
                         ctrl.mem_read, prog_addr};

  // R7
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !take |=> pc_q == $past(pc_q) + XLEN'(4));

  // R6
  br_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && take |=> pc_q == $past(pc_q) + ($past(imm) << 1));

  // R6
  br_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && take |-> rs1_d == rs2_d);

  // R1
  hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pc_q == '0);

  // R9
  illegal_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !ctrl.legal |-> !wb_we_o && !st_we_o);

  // R5
  store_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_we_o |-> !wb_we_o);
endmodule

// File: tb/sc64_core_bench.sv
module sc64_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPROG = 17;
  localparam int NVEC = 17;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_we, prog_dmem;
  logic [5:0]  prog_addr;
  logic [63:0] prog_data;
  logic [63:0] pc_o, wb_data_o, st_addr_o, st_data_o;
  logic        wb_we_o, st_we_o;
  logic [4:0]  wb_rd_o;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc64_core u_sc64_core (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_dmem(prog_dmem),
    .prog_addr(prog_addr), .prog_data(prog_data), .pc_o(pc_o),
    .wb_we_o(wb_we_o), .wb_rd_o(wb_rd_o), .wb_data_o(wb_data_o),
    .st_we_o(st_we_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  function automatic logic [31:0] r_t(input logic [6:0] f7, input logic [4:0] s2,
                                      input logic [4:0] s1, input logic [2:0] f3,
                                      input logic [4:0] d);
    return {f7, s2, s1, f3, d, 7'b0110011};
  endfunction

  function automatic logic [31:0] i_t(input logic [11:0] im, input logic [4:0] s1,
                                      input logic [2:0] f3, input logic [4:0] d,
                                      input logic [6:0] op);
    return {im, s1, f3, d, op};
  endfunction

  function automatic logic [31:0] s_t(input logic [11:0] im, input logic [4:0] s2,
                                      input logic [4:0] s1);
    return {im[11:5], s2, s1, 3'b011, im[4:0], 7'b0100011};
  endfunction

  function automatic logic [31:0] b_t(input logic [11:0] f, input logic [4:0] s2,
                                      input logic [4:0] s1);
    return {f[11], f[9:4], s2, s1, 3'b000, f[3:0], f[10], 7'b1100011};
  endfunction

  localparam logic [6:0] OP_I = 7'b0010011;
  localparam logic [6:0] OP_L = 7'b0000011;

  localparam logic [31:0] PROG [NPROG] = '{
    i_t(12'd8, 5'd0, 3'b000, 5'd1, OP_I),          // 0  addi x1,x0,8
    i_t(12'd0, 5'd0, 3'b011, 5'd2, OP_L),          // 4  ld x2,0(x0)
    i_t(12'd0, 5'd1, 3'b011, 5'd3, OP_L),          // 8  ld x3,0(x1)
    r_t(7'b0000000, 5'd3, 5'd2, 3'b000, 5'd4),     // 12 add x4,x2,x3
    r_t(7'b0100000, 5'd1, 5'd3, 3'b000, 5'd5),     // 16 sub x5,x3,x1
    r_t(7'b0000000, 5'd3, 5'd2, 3'b111, 5'd6),     // 20 and x6,x2,x3
    r_t(7'b0000000, 5'd3, 5'd2, 3'b110, 5'd7),     // 24 or  x7,x2,x3
    i_t(12'hFF3, 5'd0, 3'b000, 5'd8, OP_I),        // 28 addi x8,x0,-13
    s_t(12'd16, 5'd8, 5'd1),                       // 32 sd x8,16(x1)
    i_t(12'd24, 5'd0, 3'b011, 5'd9, OP_L),         // 36 ld x9,24(x0)
    i_t(12'd5, 5'd0, 3'b000, 5'd0, OP_I),          // 40 addi x0,x0,5
    r_t(7'b0000000, 5'd1, 5'd0, 3'b000, 5'd10),    // 44 add x10,x0,x1
    b_t(12'd4, 5'd3, 5'd1),                        // 48 beq x1,x3 (unequal)
    b_t(12'd4, 5'd5, 5'd5),                        // 52 beq x5,x5 -> 60
    i_t(12'd99, 5'd0, 3'b000, 5'd11, OP_I),        // 56 skipped
    32'hFFFF_FFFF,                                 // 60 unknown opcode
    b_t(12'hFF0, 5'd0, 5'd0)                       // 64 beq x0,x0,-16 -> 32
  };

  typedef struct packed {
    logic [63:0] pc;
    logic        wb_we;
    logic [4:0]  rd;
    logic [63:0] wbd;
    logic        st_we;
    logic [63:0] sta;
    logic [63:0] std;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] M13 = 64'hFFFF_FFFF_FFFF_FFF3;

  localparam vec_t VEC [NVEC] = '{
    '{64'd0,  1'b1, 5'd1,  64'd8,                   1'b0, 64'd0,  64'd0, 8'd3},  // R3
    '{64'd4,  1'b1, 5'd2,  64'h1111_2222_3333_4444, 1'b0, 64'd0,  64'd0, 8'd4},  // R4
    '{64'd8,  1'b1, 5'd3,  64'h0000_0000_0000_00F0, 1'b0, 64'd0,  64'd0, 8'd4},  // R4
    '{64'd12, 1'b1, 5'd4,  64'h1111_2222_3333_4534, 1'b0, 64'd0,  64'd0, 8'd2},  // R2 add
    '{64'd16, 1'b1, 5'd5,  64'h0000_0000_0000_00E8, 1'b0, 64'd0,  64'd0, 8'd2},  // R2 sub
    '{64'd20, 1'b1, 5'd6,  64'h0000_0000_0000_0040, 1'b0, 64'd0,  64'd0, 8'd2},  // R2 and
    '{64'd24, 1'b1, 5'd7,  64'h1111_2222_3333_44F4, 1'b0, 64'd0,  64'd0, 8'd2},  // R2 or
    '{64'd28, 1'b1, 5'd8,  M13,                     1'b0, 64'd0,  64'd0, 8'd3},  // R3 negative
    '{64'd32, 1'b0, 5'd0,  64'd0,                   1'b1, 64'd24, M13,   8'd5},  // R5
    '{64'd36, 1'b1, 5'd9,  M13,                     1'b0, 64'd0,  64'd0, 8'd10}, // R10 reload
    '{64'd40, 1'b0, 5'd0,  64'd0,                   1'b0, 64'd0,  64'd0, 8'd8},  // R8
    '{64'd44, 1'b1, 5'd10, 64'd8,                   1'b0, 64'd0,  64'd0, 8'd8},  // R8 reads 0
    '{64'd48, 1'b0, 5'd0,  64'd0,                   1'b0, 64'd0,  64'd0, 8'd7},  // R7
    '{64'd52, 1'b0, 5'd0,  64'd0,                   1'b0, 64'd0,  64'd0, 8'd7},  // R7 pc seen
    '{64'd60, 1'b0, 5'd0,  64'd0,                   1'b0, 64'd0,  64'd0, 8'd6},  // R6 taken fwd
    '{64'd64, 1'b0, 5'd0,  64'd0,                   1'b0, 64'd0,  64'd0, 8'd9},  // R9
    '{64'd32, 1'b1 ^ 1'b1, 5'd0, 64'd0,             1'b1, 64'd24, M13,   8'd6}   // R6 -16 -> -32
  };

  task automatic chk(input int req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic sel, input int idx, input logic [63:0] d);
    prog_we   = 1'b1;
    prog_dmem = sel;
    prog_addr = 6'(idx);
    prog_data = d;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prog_we = 1'b0; prog_dmem = 1'b0; prog_addr = '0; prog_data = '0;
    repeat (2) @(negedge clk);
    // R1 state while held in reset
    chk(1, "pc in reset", pc_o, 64'd0);
    chk(1, "wb_we in reset", {63'd0, wb_we_o}, 64'd0);
    chk(1, "st_we in reset", {63'd0, st_we_o}, 64'd0);

    for (int i = 0; i < NPROG; i++) load(1'b0, i, {32'd0, PROG[i]});
    load(1'b1, 0, 64'h1111_2222_3333_4444);
    load(1'b1, 1, 64'h0000_0000_0000_00F0);
    prog_we = 1'b0;

    rst_n = 1'b1;
    @(negedge clk);
    // R1 no advance one edge after release
    chk(1, "pc after first edge", pc_o, 64'd0);

    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      chk(int'(VEC[k].req), "pc", pc_o, VEC[k].pc);
      chk(int'(VEC[k].req), "wb_we", {63'd0, wb_we_o}, {63'd0, VEC[k].wb_we});
      chk(int'(VEC[k].req), "st_we", {63'd0, st_we_o}, {63'd0, VEC[k].st_we});
      if (VEC[k].wb_we) begin
        chk(int'(VEC[k].req), "wb_rd", {59'd0, wb_rd_o}, {59'd0, VEC[k].rd});
        chk(int'(VEC[k].req), "wb_data", wb_data_o, VEC[k].wbd);
      end
      if (VEC[k].st_we) begin
        chk(int'(VEC[k].req), "st_addr", st_addr_o, VEC[k].sta);
        chk(int'(VEC[k].req), "st_data", st_data_o, VEC[k].std);
      end
    end

    @(negedge clk);
    // R10 replayed store then falls through by 4
    chk(10, "pc after replay", pc_o, 64'd36);

    // R1 asynchronous clear mid-run
    rst_n = 1'b0;
    #1;
    chk(1, "pc async clear", pc_o, 64'd0);
    chk(1, "wb_we async clear", {63'd0, wb_we_o}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, "pc hold 1", pc_o, 64'd0);
    @(negedge clk);
    chk(1, "pc hold 2", pc_o, 64'd0);
    chk(1, "first commit enabled", {63'd0, wb_we_o}, 64'd1);
    @(negedge clk);
    chk(1, "pc after first commit", pc_o, 64'd4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule